// File: doc/BRIEF.md
# Phase Interval Timer with Cascaded BCD Stages

This block times one charge or discharge phase of a cell under test. A phase length is entered as two BCD digits of hours and two BCD digits of minutes. On a load strobe the block turns that entry into a total number of minutes, held in BCD, and keeps it as the preset. A start strobe copies the preset into a BCD down-counter and starts a chain of two square-wave divider stages. Together these divide the system clock down to one step per minute. The down-counter takes one step each time the last divider's output rises.

When the count reaches zero, the block raises an expiry level and a one-clock interrupt pulse. The controller that owns the cell then switches the cell to its next phase. The expiry level holds until the next load. The divider ratios are parameters. The defaults are small so that a minute lasts only a few clocks in simulation. A real system sets them so that their product equals the number of system clocks per minute.

Top module: `phase_interval_timer`

## Requirements
- R1: While reset is held and right after it is released, `expired` and `irq` are 0 and no timing run is active.
- R2: A load pulse converts `hours_bcd` (tens digit in bits 7:4, units in bits 3:0) and `minutes_bcd` (same layout) to H*60+M minutes. Counting the posedge that samples `start` as edge 0, `expired` first reads 1 after edge (H*60+M)*DIV0*DIV1.
- R3: Each divider stage counts N enabled steps per period, and its output rises once per period. The output stays high for (N+1)/2 steps when N is odd and N/2 when N is even. Stage 0 steps on every clock of a run. Stage 1 steps on each rise of stage 0. The minute counter steps on each rise of stage 1.
- R4: The minute counter holds four valid BCD digits. Its decrement borrows across digit boundaries (0100 becomes 0099), and it stops at 0000.
- R5: Once set, `expired` stays 1 until a load pulse, which clears it in the cycle after the load edge.
- R6: `irq` is high for exactly one cycle, and it is high exactly in the cycle in which `expired` rises.
- R7: Starting with a preset of 0 minutes sets `expired` and `irq` right after the start edge itself.
- R8: A start pulse while `expired` is 1 has no effect: no new `irq`, and `expired` stays 1.
- R9: A start pulse during a run restarts the full preset interval and both divider stages, counted from that new start edge.
- R10: A load pulse during a run halts it. No expiry follows until the next start, which then times the newly loaded value.
- R11: If load and start are high in the same cycle, the load takes effect and the start is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Strobe: latch hours and minutes as the new preset and halt any run |
| hours_bcd | input | 8 | Hours, two BCD digits |
| minutes_bcd | input | 8 | Minutes, two BCD digits |
| start | input | 1 | Strobe: begin timing the preset interval |
| expired | output | 1 | High from the end of the interval until the next load |
| irq | output | 1 | One-clock pulse at the end of the interval |

## Verification
The bench uses intervals whose BCD counts cross a tens boundary (10, 70, 100, 120, 605) and the largest entry, 99 h 59 min. A decrement that borrows wrongly, or a wrong hours-to-minutes conversion, shifts the expiry edge by whole minutes or makes the count run away. The expiry is sampled one edge early and on the exact edge, so a divider that is off by one in either stage shows up as expiry a few clocks late or early. A zero preset must expire on the start edge and not wrap to 9999. A start after expiry must not fire a second pulse. A restart mid-run and a load mid-run must reset or halt the count rather than let the old run finish.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int CNT_DIGITS = 4;
    localparam int CNT_W      = 4 * CNT_DIGITS;

    typedef logic [CNT_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t preset;
        logic run;
        logic expired;
        logic irq;
    } ctl_t;

    function automatic bcd_t to_bcd(input int unsigned value);
        bcd_t        r;
        int unsigned v;
        r = '0;
        v = value;
        for (int i = 0; i < CNT_DIGITS; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    // one step down with decimal borrow; caller keeps zero from reaching here
    function automatic bcd_t bcd_minus_one(input bcd_t b);
        bcd_t r;
        logic borrow;
        r      = b;
        borrow = 1'b1;
        for (int i = 0; i < CNT_DIGITS; i++) begin
            if (borrow) begin
                if (r[4*i +: 4] == 4'd0) begin
                    r[4*i +: 4] = 4'd9;
                end else begin
                    r[4*i +: 4] = r[4*i +: 4] - 4'd1;
                    borrow      = 1'b0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pit_sq_div.sv
module pit_sq_div
    import pit_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic tick,
    output logic sq
);

    localparam bcd_t TOP  = to_bcd(N - 1);
    localparam bcd_t HALF = to_bcd(N / 2);

    bcd_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (restart) begin
            cnt_d = TOP;
        end else if (step) begin
            if (cnt_q == '0) begin
                cnt_d = TOP;
                tick  = 1'b1;
            end else begin
                cnt_d = bcd_minus_one(cnt_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= TOP;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // BCD keeps numeric order, so a plain compare gives the square wave
    assign sq = (cnt_q >= HALF);

endmodule

// File: rtl/pit_min_conv.sv
module pit_min_conv
    import pit_pkg::*;
(
    input  logic [7:0] hours_bcd,
    input  logic [7:0] minutes_bcd,
    output bcd_t       total_bcd
);

    int unsigned hrs, mins;

    always_comb begin
        hrs       = 32'(hours_bcd[7:4]) * 10 + 32'(hours_bcd[3:0]);
        mins      = 32'(minutes_bcd[7:4]) * 10 + 32'(minutes_bcd[3:0]);
        total_bcd = to_bcd(hrs * 60 + mins);
    end

endmodule

// File: rtl/pit_tc_stage.sv
module pit_tc_stage
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  bcd_t load_val,
    input  logic step,
    output bcd_t cnt,
    output logic at_one
);

    localparam bcd_t ONE = to_bcd(1);

    bcd_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_d = bcd_minus_one(cnt_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt    = cnt_q;
    assign at_one = (cnt_q == ONE);

endmodule

// File: rtl/phase_interval_timer.sv
module phase_interval_timer
    import pit_pkg::*;
#(
    parameter int DIV0 = 4,
    parameter int DIV1 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] hours_bcd,
    input  logic [7:0] minutes_bcd,
    input  logic       start,
    output logic       expired,
    output logic       irq
);

    localparam int NSTG             = 2;
    localparam int DIVS [NSTG]      = '{DIV0, DIV1};

    ctl_t            st_d, st_q;
    bcd_t            conv_total;
    bcd_t            tc_cnt;
    logic            tc_at_one;
    logic            tc_load;
    logic            tc_step;
    logic            div_restart;
    logic [NSTG-1:0] div_tick;
    logic [NSTG-1:0] div_sq;
    logic [NSTG-1:0] stage_en;
    logic            minute_tick;

    pit_min_conv u_conv (
        .hours_bcd   (hours_bcd),
        .minutes_bcd (minutes_bcd),
        .total_bcd   (conv_total)
    );

    // each stage steps on the rise of the stage before it
    assign stage_en = {div_tick[NSTG-2:0], st_q.run};

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        pit_sq_div #(.N(DIVS[g])) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (div_restart),
            .step    (stage_en[g]),
            .tick    (div_tick[g]),
            .sq      (div_sq[g])
        );
    end

    assign minute_tick = div_tick[NSTG-1];
    assign tc_step     = minute_tick & st_q.run;

    pit_tc_stage u_tc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tc_load),
        .load_val (st_q.preset),
        .step     (tc_step),
        .cnt      (tc_cnt),
        .at_one   (tc_at_one)
    );

    always_comb begin
        st_d        = st_q;
        st_d.irq    = 1'b0;
        div_restart = 1'b0;
        tc_load     = 1'b0;
        if (load) begin
            st_d.preset  = conv_total;
            st_d.run     = 1'b0;
            st_d.expired = 1'b0;
        end else if (start && !st_q.expired) begin
            div_restart = 1'b1;
            tc_load     = 1'b1;
            if (st_q.preset == '0) begin
                st_d.run     = 1'b0;
                st_d.expired = 1'b1;
                st_d.irq     = 1'b1;
            end else begin
                st_d.run = 1'b1;
            end
        end else if (tc_step && tc_at_one) begin
            st_d.run     = 1'b0;
            st_d.expired = 1'b1;
            st_d.irq     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired = st_q.expired;
    assign irq     = st_q.irq;

endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic load,
    input logic expired,
    input logic irq,
    input logic run,
    input logic s0_tick,
    input logic s0_sq,
    input bcd_t tc_cnt
);

    function automatic logic digits_ok(input bcd_t b);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < CNT_DIGITS; i++) begin
            if (b[4*i +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $rose(expired)); // R6
    AST_RISE_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> irq); // R6
    AST_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R5
    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok(tc_cnt)); // R4
    AST_TICK_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        s0_tick |=> s0_sq); // R3
    AST_IDLE_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> !run); // R8

endmodule

bind phase_interval_timer pit_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .expired (expired),
    .irq     (irq),
    .run     (st_q.run),
    .s0_tick (div_tick[0]),
    .s0_sq   (div_sq[0]),
    .tc_cnt  (tc_cnt)
);

// File: tb/phase_interval_timer_test.sv
`timescale 1ns/1ps
module phase_interval_timer_test;

    localparam int D0 = 4;
    localparam int D1 = 3;
    localparam int P  = D0 * D1;
    localparam int NV = 8;
    // {hours BCD, minutes BCD, expected total minutes}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 8'h01, 16'd1},
        {8'h00, 8'h09, 16'd9},
        {8'h00, 8'h10, 16'd10},
        {8'h00, 8'h59, 16'd59},
        {8'h01, 8'h10, 16'd70},
        {8'h01, 8'h40, 16'd100},
        {8'h02, 8'h00, 16'd120},
        {8'h10, 8'h05, 16'd605}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       start = 1'b0;
    logic [7:0] hours_bcd = 8'h00;
    logic [7:0] minutes_bcd = 8'h00;
    logic       expired, irq;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2.5 clk = ~clk;

    phase_interval_timer #(.DIV0(D0), .DIV1(D1)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .hours_bcd   (hours_bcd),
        .minutes_bcd (minutes_bcd),
        .start       (start),
        .expired     (expired),
        .irq         (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] h, input logic [7:0] m);
        load = 1'b1; hours_bcd = h; minutes_bcd = m;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    // start edge already taken; expiry due after edge P*t
    task automatic expect_expiry(input int t, input string req);
        wait_edges(P * t - 1);
        check(expired == 1'b0, {req, " early"}, int'(expired), 0);
        wait_edges(1);
        check(expired == 1'b1, {req, " on time"}, int'(expired), 1);
        check(irq == 1'b1, {req, " irq R6"}, int'(irq), 1);
        wait_edges(1);
        check(irq == 1'b0, "R6 irq width", int'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int seen;
        @(negedge clk);
        check(expired == 1'b0 && irq == 1'b0, "R1 during reset", int'({expired, irq}), 0);
        wait_edges(2);
        rst_n = 1'b1;
        wait_edges(1);
        check(expired == 1'b0 && irq == 1'b0, "R1 after reset", int'({expired, irq}), 0);

        // R2 R3 R4 table walk
        for (int i = 0; i < NV; i++) begin
            do_load(VEC[i][31:24], VEC[i][23:16]);
            check(expired == 1'b0, "R5 load clears", int'(expired), 0);
            do_start();
            expect_expiry(int'(VEC[i][15:0]), "R2 R3 R4 interval");
        end

        // R5 hold for a while without load
        wait_edges(40);
        check(expired == 1'b1, "R5 hold", int'(expired), 1);

        // R7 zero preset
        do_load(8'h00, 8'h00);
        do_start();
        check(expired == 1'b1 && irq == 1'b1, "R7 zero interval", int'({expired, irq}), 3);
        wait_edges(1);
        check(irq == 1'b0, "R7 irq width", int'(irq), 0);

        // R8 start while expired
        do_start();
        seen = 0;
        for (int k = 0; k < 3 * P; k++) begin
            if (irq) seen++;
            wait_edges(1);
        end
        check(seen == 0, "R8 no new irq", seen, 0);
        check(expired == 1'b1, "R8 expiry kept", int'(expired), 1);

        // R9 restart mid-run
        do_load(8'h00, 8'h02);
        do_start();
        wait_edges(17);
        do_start();
        expect_expiry(2, "R9 restart");

        // R10 load halts run
        do_load(8'h00, 8'h01);
        do_start();
        wait_edges(5);
        do_load(8'h00, 8'h03);
        seen = 0;
        for (int k = 0; k < 5 * P; k++) begin
            if (irq || expired) seen++;
            wait_edges(1);
        end
        check(seen == 0, "R10 halted", seen, 0);
        do_start();
        expect_expiry(3, "R10 new value");

        // R11 load and start together: load wins, nothing runs
        start = 1'b1; load = 1'b1; hours_bcd = 8'h00; minutes_bcd = 8'h00;
        wait_edges(1);
        start = 1'b0; load = 1'b0;
        check(expired == 1'b0 && irq == 1'b0, "R11 start dropped", int'({expired, irq}), 0);
        wait_edges(2 * P);
        check(expired == 1'b0, "R11 idle", int'(expired), 0);

        // R2 R4 largest entry
        do_load(8'h99, 8'h59);
        do_start();
        expect_expiry(5999, "R2 R4 max entry");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule